// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-port synchronous memory with a 36-bit word. The word is split into four 9-bit byte lanes. Address, controls and lane write enables are registered on a rising clock edge. The data phase of every operation comes exactly two edges later, and a read's data phase and a write's data phase take the same slot. Reads and writes can therefore be issued on consecutive cycles in any order, and the bus never needs an idle cycle to change direction. A write reaches the array at the edge where its data is captured. A read issued right behind a write to the same word gets the new bytes through a forwarding path, which merges them in front of the synchronous array read.

A stall input freezes the whole block. When stall is high, the clock edge is ignored and every register keeps its value, including both pipeline stages and the burst counter. There are three chip enables, each with its own polarity. A load cycle with any chip enable inactive starts no operation, but work already in the pipeline still completes. A burst unit turns one loaded address into a run of four words, in linear or interleaved order, and then wraps. The data bus is modelled as separate input, output and drive-enable ports. An asynchronous output enable can cut the drive at any moment.

Top module: `zbt_sram`

## Requirements
- R1: Inputs are sampled only on rising clock edges. For a read loaded at edge k, the stored word appears on dq_out with dq_oe high from edge k+2 until edge k+3, provided oe_n is low.
- R2: For a write loaded at edge k, dq_in is captured at edge k+2. Only the lanes whose lane_we bit was high at edge k are updated; lane i is bits 9*i+8 down to 9*i.
- R3: Reads and writes can be issued on every cycle in any mix. A read always returns the latest data written in issue order, including a read issued on the cycle right after a write to the same address.
- R4: While stall is high, clock edges have no effect. Pipeline stages, the burst state and the output state all hold their values.
- R5: A load cycle (advance low) in which ce_a_n is high, ce_b is low or ce_c_n is high starts no operation and ends any burst. Operations already issued still complete.
- R6: dq_oe is low two edges after a deselect or after a write is loaded.
- R7: When oe_n is high, dq_oe is low at once, with no clock edge needed.
- R8: A selected load with advance low starts a burst at offset 0. Each following cycle with advance high issues the next word. When lin_order is 1, the low two address bits are (base + n) mod 4. When lin_order is 0, they are base XOR n. The upper bits stay fixed, and after four words the sequence wraps.
- R9: During a burst, wr_n is ignored. The direction is the one sampled on the load cycle.
- R10: A cycle with advance high and no active burst (after reset or after a deselect) starts no operation.
- R11: After reset, no operation is pending and dq_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | High: ignore this clock edge entirely |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| advance | input | 1 | 0: load a new address, 1: step the burst |
| wr_n | input | 1 | 0: write, 1: read (sampled on load cycles) |
| lin_order | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | ADDR_W | Word address |
| lane_we | input | LANES | Per-lane write enable, active high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | LANES*LANE_W | Write data for the current data phase |
| dq_out | output | LANES*LANE_W | Read data (zero when not driving) |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
A fault in the two pipeline stages shows at the ports two edges after the bad issue: either a drive-enable pulse in the wrong cycle or a word landing in the wrong slot. Any such error breaks the strict order in which the scoreboard expects results. A stale forwarding register or a lost lane mask stays hidden in the array until that address is read again. For that reason the random phase rereads addresses often, right after writing them, and a bad burst counter shows up on the next beat as a word from the wrong address.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
   localparam int BEAT_W = 2;

   typedef enum logic {
      ORD_INTERLEAVE = 1'b0,
      ORD_LINEAR     = 1'b1
   } burst_order_e;

   // low address bits of beat n for a burst that started at offset start
   function automatic logic [BEAT_W-1:0] beat_offset(input logic [BEAT_W-1:0] start,
                                                     input logic [BEAT_W-1:0] beat,
                                                     input burst_order_e order);
      return (order == ORD_LINEAR) ? start + beat : start ^ beat;
   endfunction
endpackage

// File: rtl/zbt_burst_ctr.sv
module zbt_burst_ctr
   import zbt_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              load,
   input  logic              adv,
   input  burst_order_e      order,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out
);
   logic [ADDR_W-1:0] base_q;
   logic [BEAT_W-1:0] beat_q;
   logic [BEAT_W-1:0] beat_nx;

   assign beat_nx  = beat_q + 1'b1;
   assign addr_out = load ? addr_in
                          : {base_q[ADDR_W-1:BEAT_W],
                             beat_offset(base_q[BEAT_W-1:0], beat_nx, order)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         beat_q <= '0;
      end else if (en) begin
         if (load) begin
            base_q <= addr_in;
            beat_q <= '0;
         end else if (adv) begin
            beat_q <= beat_nx;
         end
      end
   end
endmodule

// File: rtl/zbt_ctrl.sv
module zbt_ctrl #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              load,
   input  logic              sel,
   input  logic              wr_n,
   input  logic [LANES-1:0]  lane_we,
   input  logic [ADDR_W-1:0] op_addr,
   output logic              ctr_load,
   output logic              ctr_adv,
   output logic              burst_on,
   output logic              dir_wr,
   output logic              s1_v,
   output logic              s1_wr,
   output logic [ADDR_W-1:0] s1_addr,
   output logic              s2_v,
   output logic              s2_wr,
   output logic [ADDR_W-1:0] s2_addr,
   output logic [LANES-1:0]  s2_lanes
);
   logic             issue;
   logic             issue_wr;
   logic [LANES-1:0] s1_lanes;

   assign ctr_load = load & sel;
   assign ctr_adv  = ~load & burst_on;
   assign issue    = ctr_load | ctr_adv;
   assign issue_wr = load ? ~wr_n : dir_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         burst_on <= 1'b0;
         dir_wr   <= 1'b0;
         s1_v     <= 1'b0;
         s1_wr    <= 1'b0;
         s1_addr  <= '0;
         s1_lanes <= '0;
         s2_v     <= 1'b0;
         s2_wr    <= 1'b0;
         s2_addr  <= '0;
         s2_lanes <= '0;
      end else if (en) begin
         if (load) burst_on <= sel;
         if (ctr_load) dir_wr <= ~wr_n;
         s1_v     <= issue;
         s1_wr    <= issue_wr;
         s1_addr  <= op_addr;
         s1_lanes <= lane_we;
         s2_v     <= s1_v;
         s2_wr    <= s1_wr;
         s2_addr  <= s1_addr;
         s2_lanes <= s1_lanes;
      end
   end
endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic [ADDR_W-1:0]       rd_addr,
   input  logic                    s2_v,
   input  logic                    s2_wr,
   input  logic [ADDR_W-1:0]       s2_addr,
   input  logic [LANES-1:0]        s2_lanes,
   input  logic [LANES*LANE_W-1:0] wr_data,
   output logic [LANES*LANE_W-1:0] dout_q,
   output logic                    drive_q
);
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int WORD_W = LANES * LANE_W;

   logic              wr_go;
   logic              rd_go;
   logic              fwd_v;
   logic [ADDR_W-1:0] fwd_addr;
   logic [LANES-1:0]  fwd_lanes;
   logic [WORD_W-1:0] fwd_data;
   logic              fwd_hit;
   logic [WORD_W-1:0] merged;

   assign wr_go   = s2_v & s2_wr;
   assign rd_go   = s2_v & ~s2_wr;
   assign fwd_hit = fwd_v & (fwd_addr == s2_addr);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] rd_lane;

      always_ff @(posedge clk) begin
         if (en) begin
            if (wr_go && s2_lanes[g]) mem[s2_addr] <= wr_data[g*LANE_W +: LANE_W];
            rd_lane <= mem[rd_addr];
         end
      end

      // write committed one edge ago was not visible to the array read
      assign merged[g*LANE_W +: LANE_W] = (fwd_hit && fwd_lanes[g])
                                          ? fwd_data[g*LANE_W +: LANE_W] : rd_lane;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fwd_v     <= 1'b0;
         fwd_addr  <= '0;
         fwd_lanes <= '0;
         fwd_data  <= '0;
         drive_q   <= 1'b0;
         dout_q    <= '0;
      end else if (en) begin
         fwd_v     <= wr_go;
         fwd_addr  <= s2_addr;
         fwd_lanes <= s2_lanes;
         fwd_data  <= wr_data;
         drive_q   <= rd_go;
         if (rd_go) dout_q <= merged;
      end
   end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
   import zbt_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    stall,
   input  logic                    ce_a_n,
   input  logic                    ce_b,
   input  logic                    ce_c_n,
   input  logic                    advance,
   input  logic                    wr_n,
   input  logic                    lin_order,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES-1:0]        lane_we,
   input  logic                    oe_n,
   input  logic [LANES*LANE_W-1:0] dq_in,
   output logic [LANES*LANE_W-1:0] dq_out,
   output logic                    dq_oe
);
   localparam int WORD_W = LANES * LANE_W;

   if (ADDR_W <= BEAT_W) begin : g_bad_addr
      $error("zbt_sram: ADDR_W must exceed the burst offset width");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("zbt_sram: LANES and LANE_W must be positive");
   end

   logic              en;
   logic              sel;
   logic              ctr_load;
   logic              ctr_adv;
   logic              burst_on;
   logic              dir_wr;
   logic [ADDR_W-1:0] op_addr;
   logic              s1_v;
   logic              s1_wr;
   logic [ADDR_W-1:0] s1_addr;
   logic              s2_v;
   logic              s2_wr;
   logic [ADDR_W-1:0] s2_addr;
   logic [LANES-1:0]  s2_lanes;
   logic [WORD_W-1:0] dout_q;
   logic              drive_q;

   assign en  = ~stall;
   assign sel = ~ce_a_n & ce_b & ~ce_c_n;

   zbt_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .load     (ctr_load),
      .adv      (ctr_adv),
      .order    (burst_order_e'(lin_order)),
      .addr_in  (addr),
      .addr_out (op_addr)
   );

   zbt_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .load     (~advance),
      .sel      (sel),
      .wr_n     (wr_n),
      .lane_we  (lane_we),
      .op_addr  (op_addr),
      .ctr_load (ctr_load),
      .ctr_adv  (ctr_adv),
      .burst_on (burst_on),
      .dir_wr   (dir_wr),
      .s1_v     (s1_v),
      .s1_wr    (s1_wr),
      .s1_addr  (s1_addr),
      .s2_v     (s2_v),
      .s2_wr    (s2_wr),
      .s2_addr  (s2_addr),
      .s2_lanes (s2_lanes)
   );

   zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .rd_addr  (s1_addr),
      .s2_v     (s2_v),
      .s2_wr    (s2_wr),
      .s2_addr  (s2_addr),
      .s2_lanes (s2_lanes),
      .wr_data  (dq_in),
      .dout_q   (dout_q),
      .drive_q  (drive_q)
   );

   assign dq_oe  = drive_q & ~oe_n;
   assign dq_out = dq_oe ? dout_q : '0;
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk (
   input logic clk,
   input logic rst_n,
   input logic stall,
   input logic advance,
   input logic sel,
   input logic burst_on,
   input logic dir_wr,
   input logic s1_v,
   input logic s1_wr,
   input logic s2_v,
   input logic s2_wr,
   input logic drive_q,
   input logic oe_n,
   input logic dq_oe
);
   a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> $stable({s1_v, s1_wr, s2_v, s2_wr, drive_q, burst_on, dir_wr}));

   a_r1_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && s2_v && !s2_wr) |=> drive_q);

   a_r6_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && !(s2_v && !s2_wr)) |=> !drive_q);

   a_r5_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && !advance && !sel) |=> (!s1_v && !burst_on));

   a_r5_drains: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && s1_v) |=> (s2_v && (s2_wr == $past(s1_wr))));

   a_r9_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && advance && burst_on) |=> (s1_v && (s1_wr == $past(dir_wr))));

   a_r10_idle_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && advance && !burst_on) |=> !s1_v);

   a_r7_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dq_oe);
endmodule

bind zbt_sram zbt_sram_chk chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .stall    (stall),
   .advance  (advance),
   .sel      (sel),
   .burst_on (burst_on),
   .dir_wr   (dir_wr),
   .s1_v     (s1_v),
   .s1_wr    (s1_wr),
   .s2_v     (s2_v),
   .s2_wr    (s2_wr),
   .drive_q  (drive_q),
   .oe_n     (oe_n),
   .dq_oe    (dq_oe)
);

// File: tb/zbt_sram_tb_top.sv
`timescale 1ns/1ps
module zbt_sram_tb_top;
   localparam int AW = 8;
   localparam int NL = 4;
   localparam int LW = 9;
   localparam int WW = NL * LW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          stall = 1'b0;
   logic          ce_a_n = 1'b1, ce_b = 1'b0, ce_c_n = 1'b1;
   logic          advance = 1'b0, wr_n = 1'b1, lin_order = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [NL-1:0] lane_we = '0;
   logic          oe_n = 1'b0;
   logic [WW-1:0] dq_in = '0;
   logic [WW-1:0] dq_out;
   logic          dq_oe;

   always #2.5 clk = ~clk;

   zbt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut_i (
      .clk(clk), .rst_n(rst_n), .stall(stall), .ce_a_n(ce_a_n), .ce_b(ce_b),
      .ce_c_n(ce_c_n), .advance(advance), .wr_n(wr_n), .lin_order(lin_order),
      .addr(addr), .lane_we(lane_we), .oe_n(oe_n), .dq_in(dq_in),
      .dq_out(dq_out), .dq_oe(dq_oe)
   );

   typedef struct {
      bit            drv;
      logic [WW-1:0] data;
      string         tag;
   } exp_t;

   exp_t          sb[$];
   int            checks = 0;
   int            fails  = 0;
   logic [WW-1:0] refm [1<<AW];

   // bench-side burst model and data pipeline (kind: 0 none, 1 read, 2 write)
   bit            b_on = 0, b_wr = 0;
   logic [AW-1:0] b_base = '0;
   logic [1:0]    b_cnt = '0;
   int            p1_kind = 0, p2_kind = 0;
   logic [WW-1:0] p1_data = '0, p2_data = '0;
   string         p1_tag = "R11", p2_tag = "R11";

   function automatic logic [WW-1:0] rnd_word();
      return WW'({$urandom, $urandom});
   endfunction

   task automatic check(input bit ok, input string req, input logic [WW-1:0] act,
                        input logic [WW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // driver: one cycle of stimulus; pushes the result expected after the next edge
   task automatic step(input bit st, input bit adv, input bit wrn, input bit selok,
                       input logic [AW-1:0] a, input logic [NL-1:0] ln, input bit lin,
                       input string tag);
      int            kind;
      logic [AW-1:0] oa;
      logic [WW-1:0] d;
      int            pick;
      @(negedge clk); #1;
      stall = st; advance = adv; wr_n = wrn; addr = a; lane_we = ln; lin_order = lin;
      ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0;
      if (!selok) begin
         pick = $urandom_range(2);
         if (pick == 0) ce_a_n = 1'b1;
         else if (pick == 1) ce_b = 1'b0;
         else ce_c_n = 1'b1;
      end
      dq_in = (p2_kind == 2) ? p2_data : rnd_word();
      if (st) return;
      kind = 0; oa = '0; d = '0;
      if (!adv) begin
         if (selok) begin
            b_on = 1; b_base = a; b_cnt = 0; b_wr = !wrn;
            kind = b_wr ? 2 : 1; oa = a;
         end else b_on = 0;
      end else if (b_on) begin
         b_cnt = b_cnt + 1'b1;
         oa = {b_base[AW-1:2], lin ? b_base[1:0] + b_cnt : b_base[1:0] ^ b_cnt};
         kind = b_wr ? 2 : 1;
      end
      if (kind == 2) begin
         d = rnd_word();
         for (int l = 0; l < NL; l++)
            if (ln[l]) refm[oa][l*LW +: LW] = d[l*LW +: LW];
      end else if (kind == 1) d = refm[oa];
      sb.push_back('{drv: (p2_kind == 1), data: p2_data, tag: p2_tag});
      p2_kind = p1_kind; p2_data = p1_data; p2_tag = p1_tag;
      p1_kind = kind;    p1_data = d;       p1_tag = tag;
   endtask

   task automatic nop(input string tag);
      step(0, 0, 1, 0, '0, '0, 1, tag);
   endtask

   // monitor: compares the output of each non-stalled edge in order
   always @(negedge clk) begin
      if (rst_n && sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         if (dq_oe !== e.drv)
            check(0, {e.tag, " drive"}, WW'(dq_oe), WW'(e.drv));
         else if (e.drv)
            check(dq_out === e.data, e.tag, dq_out, e.data);
         else
            check(1, e.tag, '0, '0);
      end
   end

   bit done = 0;
   initial begin
      #(5.0 * 150000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < (1 << AW); i++) refm[i] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R11: idle after reset
      check(dq_oe === 1'b0 && dq_out === '0, "R11", WW'(dq_oe), '0);

      // R2: fill every word with full-lane writes
      for (int i = 0; i < (1 << AW); i++) step(0, 0, 0, 1, AW'(i), '1, 1, "R2");
      nop("R6"); nop("R6");

      // R3: write then read the same word on the very next cycle, and mixed back-to-back
      step(0, 0, 0, 1, 8'h05, '1, 1, "R3");
      step(0, 0, 1, 1, 8'h05, '0, 1, "R3");
      step(0, 0, 0, 1, 8'h06, '1, 1, "R3");
      step(0, 0, 1, 1, 8'h05, '0, 1, "R3");
      step(0, 0, 1, 1, 8'h06, '0, 1, "R3");
      // R2: partial-lane write then read back
      step(0, 0, 0, 1, 8'h09, 4'b0101, 1, "R2");
      step(0, 0, 1, 1, 8'h09, '0, 1, "R2");
      step(0, 0, 0, 1, 8'h09, 4'b1000, 1, "R2");
      nop("R6");
      step(0, 0, 1, 1, 8'h09, '0, 1, "R2");
      nop("R6"); nop("R6");

      // R8: linear burst from offset 2, five beats to show the wrap
      step(0, 0, 1, 1, 8'h12, '0, 1, "R8");
      for (int i = 0; i < 4; i++) step(0, 1, 1, 1, 8'hFF, '0, 1, "R8");
      // R8: interleaved burst from offset 3
      step(0, 0, 1, 1, 8'h27, '0, 0, "R8");
      for (int i = 0; i < 4; i++) step(0, 1, 1, 1, 8'h00, '0, 0, "R8");
      nop("R6");

      // R9: burst write with wr_n toggling, then linear burst read back
      step(0, 0, 0, 1, 8'h40, '1, 1, "R9");
      for (int i = 0; i < 3; i++) step(0, 1, 1, 1, 8'h80, '1, 1, "R9");
      step(0, 0, 1, 1, 8'h40, '0, 1, "R9");
      for (int i = 0; i < 3; i++) step(0, 1, 0, 1, 8'h80, '1, 1, "R9");

      // R5: read then deselect at once; read still completes, bus released after
      step(0, 0, 1, 1, 8'h33, '0, 1, "R5");
      nop("R5"); nop("R5");
      // R10: advance with no active burst issues nothing
      step(0, 1, 1, 1, 8'h33, '0, 1, "R10");
      step(0, 1, 0, 1, 8'h34, '1, 1, "R10");
      nop("R10"); nop("R10");

      // R4: stalls inside a burst with garbage on the inputs
      step(0, 0, 1, 1, 8'h50, '0, 1, "R4");
      for (int i = 0; i < 5; i++) step(1, $urandom_range(1), 0, 1, AW'($urandom), '1, 1, "R4");
      step(0, 1, 1, 1, 8'h00, '0, 1, "R4");
      for (int i = 0; i < 3; i++) step(1, 0, 0, 1, AW'($urandom), '1, 0, "R4");
      step(0, 1, 1, 1, 8'h00, '0, 1, "R4");
      // R6: read followed by write; bus released in the write's data phase
      step(0, 0, 1, 1, 8'h60, '0, 1, "R6");
      step(0, 0, 0, 1, 8'h61, '1, 1, "R6");
      nop("R6"); nop("R6");

      // R3: random mix of loads, bursts, deselects and stalls
      for (int i = 0; i < 3000; i++)
         step($urandom_range(7) == 0, $urandom_range(9) < 4, $urandom_range(1),
              $urandom_range(9) < 8, AW'($urandom_range(15)), NL'($urandom),
              $urandom_range(1), "R3");
      nop("R6"); nop("R6"); nop("R6");

      // R7: output enable cuts the drive with no clock edge
      step(0, 0, 1, 1, 8'h05, '0, 1, "R1");
      nop("R1");
      nop("R1");
      @(posedge clk); #1;
      check(dq_oe === 1'b1, "R1", WW'(dq_oe), WW'(1));
      oe_n = 1'b1; #0.2;
      check(dq_oe === 1'b0, "R7", WW'(dq_oe), WW'(0));
      oe_n = 1'b0; #0.2;
      check(dq_oe === 1'b1 && dq_out === refm[8'h05], "R7", dq_out, refm[8'h05]);
      nop("R6"); nop("R6"); nop("R6");
      @(negedge clk); @(negedge clk);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule